// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block holds an 8-bit count register that a host can read at any time and load with a bus write. The count advances either once per instruction cycle (timer mode) or on a chosen edge of an external clock pin (counter mode). The pin is brought into the system clock domain through two flops and an edge detector, so every pin edge reaches the register a fixed number of clocks later.

A free-running prescaler can sit between the selected source and the register, dividing by a power of two from 2 to 256. It can instead be lent to a watchdog, which then receives a divided tick from it; while it is lent out, the register counts every source tick undivided. Loading the register clears the prescaler and holds off counting for two instruction cycles, so the loaded value reads back unchanged during that window. Wrapping from 0xFF to 0x00 raises a single-cycle overflow pulse.

Top module: `tmr8_prescaled`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, count_q reads 0x00 and both wrap_pulse and wdog_tick read 0.
- R2: With mode[5]=0 and mode[3]=1 (timer mode, prescaler lent out), count_q rises by one on each rising clk edge at which cycle_en is 1 and no hold is active.
- R3: With mode[5]=1 (counter mode) the count advances on pin edges only: mode[4]=0 selects the rising edge of ext_pin and mode[4]=1 the falling edge; a pin change that is stable before a clk edge shows in count_q after the third rising clk edge, counting that one.
- R4: With mode[3]=0 the prescaler divides the selected source; the rate field mode[2:0] gives a ratio of 2^(rate+1), so code 0 divides by 2 and code 7 by 256, and a source tick reaches the register when the low rate+1 bits of the prescaler are all ones.
- R5: With mode[3]=1 the register gets no division and wdog_tick pulses for one cycle on each cycle_en at which the low rate+1 prescaler bits are all ones, i.e. once per 2^(rate+1) instruction cycles; with mode[3]=0 wdog_tick stays 0.
- R6: A clk edge with wr_en=1 loads wr_data into count_q (overriding any increment), clears the prescaler, and blocks increments until two further cycle_en edges have passed.
- R7: When an increment takes count_q from 0xFF to 0x00, wrap_pulse is 1 for exactly the clk cycle in which count_q first reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_en | input | 1 | Instruction-cycle enable, one clk wide |
| ext_pin | input | 1 | External clock pin, asynchronous |
| mode | input | 8 | [5] source, [4] edge, [3] prescaler assignment, [2:0] rate |
| wr_en | input | 1 | Load strobe for the count register |
| wr_data | input | 8 | Value loaded on wr_en |
| count_q | output | 8 | Current count |
| wrap_pulse | output | 1 | One-cycle pulse on 0xFF to 0x00 wrap |
| wdog_tick | output | 1 | Divided tick for the watchdog when the prescaler is lent out |

## Verification
The hardest situation to reach is a load landing while the prescaler is partway through a long division in counter mode, with a pin edge still travelling through the synchronizer, since the hold window, the prescaler clear and the pipeline delay all interact in the following cycles. The stimulus reaches it by toggling the pin, the enable, the mode byte and the load strobe at random every cycle for thousands of cycles under a fixed seed, and a reference model in the bench predicts every output each cycle; directed phases add a load of 0xFF to force a wrap and a run at the slowest rate.

// File: rtl/tmr8_prescaled.sv
module tmr8_prescaled #(
  parameter int CW = 8,
  parameter int PW = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_en,
  input  logic          ext_pin,
  input  logic [7:0]    mode,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count_q,
  output logic          wrap_pulse,
  output logic          wdog_tick
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          sync1, sync2, sync3;
  logic [PW-1:0] psc;
  logic [HW-1:0] hold;
  logic [PW:0]   one_sh;
  logic [PW-1:0] psc_mask;
  logic          psc_full, to_tmr, pin_edge, src_tick, psc_adv, tmr_tick, inc;

  always_ff @(posedge clk) begin
    if (!rst_n) {sync1, sync2, sync3} <= 3'b000;
    else        {sync1, sync2, sync3} <= {ext_pin, sync1, sync2};
  end

  assign pin_edge = mode[4] ? (sync3 & ~sync2) : (sync2 & ~sync3);
  assign src_tick = mode[5] ? pin_edge : cycle_en;
  assign to_tmr   = ~mode[3];

  assign one_sh   = {{PW{1'b0}}, 1'b1} << ({1'b0, mode[2:0]} + 4'd1);
  assign psc_mask = one_sh[PW-1:0] - {{(PW-1){1'b0}}, 1'b1};
  assign psc_full = (psc & psc_mask) == psc_mask;

  assign psc_adv  = to_tmr ? src_tick : cycle_en;
  assign tmr_tick = to_tmr ? (src_tick & psc_full) : src_tick;
  assign inc      = tmr_tick && (hold == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       psc <= '0;
    else if (wr_en)   psc <= '0;
    else if (psc_adv) psc <= psc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          hold <= '0;
    else if (wr_en)                      hold <= HW'(HOLD_CYC);
    else if (cycle_en && hold != '0)     hold <= hold - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      wrap_pulse <= 1'b0;
      wdog_tick  <= 1'b0;
    end else begin
      wrap_pulse <= ~wr_en & inc & (&count_q);
      wdog_tick  <= ~to_tmr & cycle_en & psc_full;
      if (wr_en)    count_q <= wr_data;
      else if (inc) count_q <= count_q + 1'b1;
    end
  end

  // R6: a load shows at once, regardless of pending ticks
  p_load_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> count_q == $past(wr_data));

  // R2: without a load the count moves by at most one
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

  // R7: the wrap pulse coincides with a zero count and lasts one cycle
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> count_q == '0 && $past(count_q) == {CW{1'b1}});
  p_wrap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  // R5: the watchdog gets nothing while the prescaler serves the register
  p_wdog_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode[3]) |-> !wdog_tick);

  // R6: inside the hold window the count stays put
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0 && !wr_en) |=> count_q == $past(count_q));
endmodule

// File: tb/tmr8_prescaled_test.sv
module tmr8_prescaled_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, cycle_en = 0, ext_pin = 0, wr_en = 0;
  logic [7:0] mode = 8'h08, wr_data = 0;
  logic [7:0] count_q;
  logic wrap_pulse, wdog_tick;

  int checks = 0, fails = 0;

  tmr8_prescaled uut (.clk(clk), .rst_n(rst_n), .cycle_en(cycle_en), .ext_pin(ext_pin),
    .mode(mode), .wr_en(wr_en), .wr_data(wr_data), .count_q(count_q),
    .wrap_pulse(wrap_pulse), .wdog_tick(wdog_tick));

  always #(PERIOD/2) clk = ~clk;

  logic m_s1, m_s2, m_s3, m_wrap, m_wdog;
  logic [7:0] m_cnt, m_psc;
  int m_hold;

  function automatic logic [7:0] rate_mask(input logic [2:0] r);
    int n = int'(r) + 1;
    return 8'((1 << n) - 1);
  endfunction

  function automatic logic pin_edge_of(input logic s2, input logic s3, input logic fall);
    return fall ? (s3 && !s2) : (s2 && !s3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_cnt <= 0; m_psc <= 0;
      m_hold <= 0; m_wrap <= 0; m_wdog <= 0;
    end else begin
      logic src, full, tick, inc;
      src  = mode[5] ? pin_edge_of(m_s2, m_s3, mode[4]) : cycle_en;
      full = (m_psc & rate_mask(mode[2:0])) == rate_mask(mode[2:0]);
      tick = mode[3] ? src : (src && full);
      inc  = tick && m_hold == 0;
      m_s1 <= ext_pin; m_s2 <= m_s1; m_s3 <= m_s2;
      m_wrap <= !wr_en && inc && m_cnt == 8'hFF;
      m_wdog <= mode[3] && cycle_en && full;
      if (wr_en) m_psc <= 0;
      else if (mode[3] ? cycle_en : src) m_psc <= m_psc + 1;
      if (wr_en) m_hold <= 2;
      else if (cycle_en && m_hold != 0) m_hold <= m_hold - 1;
      if (wr_en) m_cnt <= wr_data;
      else if (inc) m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string count_tag();
    if (m_hold != 0) return "R6";
    if (mode[5]) return "R3";
    if (mode[3]) return "R2";
    return "R4";
  endfunction

  task automatic compare_all();
    check(count_tag(), count_q, m_cnt);
    check("R7", {7'b0, wrap_pulse}, {7'b0, m_wrap});
    check("R5", {7'b0, wdog_tick}, {7'b0, m_wdog});
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1", count_q, 8'h00);
    check("R1", {6'b0, wrap_pulse, wdog_tick}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1", count_q, 8'h00);
    // R2: plain timer mode
    mode = 8'h08; cycle_en = 1;
    repeat (20) step();
    check("R2", count_q, 8'd20);
    // R7: load 0xFF and watch the wrap after the hold
    wr_en = 1; wr_data = 8'hFF; step(); wr_en = 0;
    check("R6", count_q, 8'hFF);
    step(); check("R6", count_q, 8'hFF);
    step(); check("R6", count_q, 8'hFF);
    step(); check("R7", {7'b0, wrap_pulse}, 8'h01); check("R7", count_q, 8'h00);
    step(); check("R7", {7'b0, wrap_pulse}, 8'h00);
    // R4: slowest rate
    mode = 8'h07; wr_en = 1; wr_data = 8'h00; step(); wr_en = 0;
    repeat (600) step();
    // R3: both edges with the pin toggling every few cycles
    for (int e = 0; e < 2; e++) begin
      mode = e ? 8'h38 : 8'h28;
      for (int k = 0; k < 40; k++) begin
        ext_pin = ~ext_pin;
        repeat (3) step();
      end
    end
    // random mix: every rate, both sources, both edges, loads mid-count
    for (int i = 0; i < 8000; i++) begin
      cycle_en = ($urandom % 3) != 0;
      if (($urandom % 3) == 0) ext_pin = ~ext_pin;
      wr_en = ($urandom % 40) == 0;
      wr_data = 8'($urandom);
      if (($urandom % 150) == 0) mode = {2'b00, 6'($urandom)};
      step();
    end
    wr_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule